// File: doc/BRIEF.md
# Comb/Bypass Mode Controller

This block decides whether a video separation path runs its comb processing or routes its inputs straight through. Three asynchronous pins feed it: a bypass request, a select pin and the field (vertical) sync pulse. The select pin does two jobs at once. It sets the polarity of the request pin. It also chooses whether comb processing starts the moment the request allows it, or waits for the next field sync pulse. Leaving comb processing never waits for anything.

All three pins pass through a two-flop synchroniser. The request pin then goes through a run-length filter: its filtered level changes only after `FILT_LEN` consecutive equal samples, so a subcarrier-rate toggle on the pin has no effect. A registered decode of filtered request and select drives a clock-stop output for the clock generator. A small state machine (bypass, pending, comb) drives a steering output, which sets all three output selectors (combined video, luma, chroma), and a status output that is high only while comb processing is running.

Top module: `cbm_mode_ctrl`

## Requirements
- R1: The decoded request asks for bypass when the request pin and the select pin differ. With select low, request high means bypass and request low means comb. With select high, request low means bypass and request high means comb.
- R2: Bypass entry is immediate. Once the decoded request asks for bypass, steer_bypass_o goes high and comb_active_o goes low 3 clock cycles after a select pin change, or 3+FILT_LEN cycles after a request pin change. This holds in comb state and in pending state.
- R3: With select low, comb mode is entered one cycle after the decoded request asks for comb. A request pin change therefore lowers steer_bypass_o 4+FILT_LEN cycles after the change.
- R4: With select high, comb mode waits for a rising edge of the vertical sync pin. steer_bypass_o falls 3 cycles after that edge. No entry is made while no pulse arrives.
- R5: clk_stop_o is high exactly when the registered decoded request asks for bypass. It does not depend on the vertical pulse, and it is low while a synchronised entry is pending.
- R6: comb_active_o is the complement of steer_bypass_o at all times. It is high only in comb mode.
- R7: If the decoded request returns to bypass while a synchronised comb entry is pending, the entry is cancelled. A later vertical pulse then does not enter comb mode.
- R8: The request pin is filtered. Its filtered level changes only after FILT_LEN consecutive synchronised samples of the new level. A pin that toggles every cycle, or a run of FILT_LEN-1 cycles, has no effect.
- R9: While reset is asserted, and on its release, the block reports bypass: steer_bypass_o=1, clk_stop_o=1 and comb_active_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bypass_req_i | input | 1 | Asynchronous bypass request pin |
| polsel_i | input | 1 | Select pin: request polarity and comb entry timing |
| vsync_i | input | 1 | Asynchronous vertical (field) sync pulse |
| steer_bypass_o | output | 1 | High routes all output selectors to the bypass inputs |
| clk_stop_o | output | 1 | High stops the processing clock generator |
| comb_active_o | output | 1 | High while comb mode is active |

## Verification
A request pin change reaches the outputs after two synchroniser stages, FILT_LEN filter samples and the decode register. clk_stop_o and bypass steering therefore move 3+FILT_LEN cycles after the pin changes, and immediate comb entry follows one cycle later. A select pin change skips the filter and shows 3 cycles later, and a vertical pulse completes a pending entry 3 cycles after its rising edge. The bench drives every pin on a falling edge and samples on falling edges. It checks each output both one cycle before its due cycle (still old) and at its due cycle (new), for both select levels, with toggling and just-too-short request runs, and with a cancelled pending entry.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   typedef enum logic [1:0] {
      CBM_BYPASS  = 2'd0,
      CBM_PENDING = 2'd1,
      CBM_COMB    = 2'd2
   } cbm_state_e;
endpackage

// File: rtl/cbm_sync.sv
module cbm_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("cbm_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_badw
         $error("cbm_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cbm_filter.sv
module cbm_filter #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   output logic level
);
   generate
      if (LEN < 1) begin : g_bad
         $error("cbm_filter: LEN must be at least 1");
      end

      if (LEN == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level <= 1'b0;
            else        level <= smp;
         end
      end else begin : g_count
         localparam int CW = $clog2(LEN);
         localparam logic [CW-1:0] LAST = CW'(LEN - 1);
         logic [CW-1:0] run;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run   <= '0;
               level <= 1'b0;
            end else if (smp == level) begin
               run <= '0;
            end else if (run == LAST) begin
               run   <= '0;
               level <= smp;
            end else begin
               run <= run + 1'b1;
            end
         end

         always_comb begin
            assert_run_bound_R8: assert (!rst_n || run <= LAST);
         end
      end
   endgenerate

   assert_filter_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (level != $past(level)) |-> (level == $past(smp)));
endmodule

// File: rtl/cbm_fsm.sv
module cbm_fsm
   import cbm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic want_byp,
   input  logic sel_s,
   input  logic vs_rise,
   output logic steer_byp,
   output logic comb_on
);
   cbm_state_e cur, nxt;

   always_comb begin
      nxt = cur;
      unique case (cur)
         CBM_BYPASS:  if (!want_byp) nxt = sel_s ? CBM_PENDING : CBM_COMB;
         CBM_PENDING: begin
            if (want_byp)               nxt = CBM_BYPASS;
            else if (!sel_s || vs_rise) nxt = CBM_COMB;
         end
         CBM_COMB:    if (want_byp) nxt = CBM_BYPASS;
         default:     nxt = CBM_BYPASS;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= CBM_BYPASS;
      else        cur <= nxt;
   end

   assign comb_on   = (cur == CBM_COMB) && !want_byp;
   assign steer_byp = !comb_on;

   assert_leave_comb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == CBM_COMB && want_byp) |=> (cur == CBM_BYPASS));

   assert_immediate_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == CBM_BYPASS && !want_byp && !sel_s) |=> (cur == CBM_COMB));

   assert_sync_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(comb_on) && $past(sel_s)) |-> $past(vs_rise));

   assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == CBM_PENDING && want_byp) |=> (cur == CBM_BYPASS));
endmodule

// File: rtl/cbm_mode_ctrl.sv
module cbm_mode_ctrl #(
   parameter int FILT_LEN    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bypass_req_i,
   input  logic polsel_i,
   input  logic vsync_i,
   output logic steer_bypass_o,
   output logic clk_stop_o,
   output logic comb_active_o
);
   localparam int NPINS = 3;

   logic [NPINS-1:0] pins_s;
   logic req_s, sel_s, vs_s, vs_d, vs_rise;
   logic req_f, want_q;

   cbm_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({vsync_i, polsel_i, bypass_req_i}),
      .q     (pins_s)
   );

   assign req_s = pins_s[0];
   assign sel_s = pins_s[1];
   assign vs_s  = pins_s[2];

   cbm_filter #(.LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .smp   (req_s),
      .level (req_f)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_d   <= 1'b0;
         want_q <= 1'b1;
      end else begin
         vs_d   <= vs_s;
         want_q <= req_f ^ sel_s;
      end
   end

   assign vs_rise = vs_s && !vs_d;

   cbm_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .want_byp  (want_q),
      .sel_s     (sel_s),
      .vs_rise   (vs_rise),
      .steer_byp (steer_bypass_o),
      .comb_on   (comb_active_o)
   );

   assign clk_stop_o = want_q;

   assert_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (clk_stop_o == ($past(req_f) ^ $past(sel_s))));

   assert_status_needs_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      comb_active_o |-> !clk_stop_o);
endmodule

// File: tb/sim_cbm_mode_ctrl.sv
`timescale 1ns/1ps
module sim_cbm_mode_ctrl;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, sel = 1'b0, vs = 1'b0;
   logic steer, cstop, comb;
   int   nvec = 0, nbad = 0;

   always #10 clk = ~clk;

   cbm_mode_ctrl #(.FILT_LEN(N)) u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .bypass_req_i   (req),
      .polsel_i       (sel),
      .vsync_i        (vs),
      .steer_bypass_o (steer),
      .clk_stop_o     (cstop),
      .comb_active_o  (comb)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic chk_mode(input string tag, input logic byp, input logic stop);
      chk({tag, " steer"}, steer, byp);
      chk({tag, " status"}, comb, ~byp);
      chk({tag, " clkstop"}, cstop, stop);
   endtask

   task automatic pulse_vs();
      vs = 1'b1;
      tick(4);
      vs = 1'b0;
   endtask

   initial begin
      #(20.0 * 200000);
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      tick(3);
      chk_mode("R9 in reset", 1'b1, 1'b1);
      rst_n = 1'b1;
      chk_mode("R9 at release", 1'b1, 1'b1);
      tick(40);

      for (int s = 0; s < 2; s++) begin
         // R1: bypass level is request != select
         sel = s[0];
         req = ~s[0];
         tick(40);
         chk_mode("R1 bypass decode", 1'b1, 1'b1);

         // R8: per-cycle toggle ignored
         for (int k = 0; k < 20; k++) begin
            req = ~req;
            tick(1);
            chk("R8 toggle clkstop", cstop, 1'b1);
         end
         req = ~s[0];
         tick(N + 4);
         chk("R8 after toggle", cstop, 1'b1);

         // R8: run of N-1 ignored
         req = s[0];
         tick(N - 1);
         req = ~s[0];
         for (int k = 0; k < N + 4; k++) begin
            tick(1);
            chk("R8 short run", cstop, 1'b1);
         end

         // Comb request
         req = s[0];
         tick(2 + N);
         chk("R8 boundary clkstop old", cstop, 1'b1);
         tick(1);
         chk("R5 clkstop released", cstop, 1'b0);
         chk("R3 steer not yet", steer, 1'b1);
         if (s == 0) begin
            tick(1);
            chk_mode("R3 immediate comb", 1'b0, 1'b0);
         end else begin
            tick(20);
            chk_mode("R4 pending no pulse", 1'b1, 1'b0);
            vs = 1'b1;
            tick(2);
            chk("R4 before due", steer, 1'b1);
            tick(1);
            chk_mode("R4 synced comb", 1'b0, 1'b0);
            tick(3);
            vs = 1'b0;
         end
         tick(10);
         chk_mode("R6 comb steady", 1'b0, 1'b0);

         // R2: leave via request pin
         req = ~s[0];
         tick(2 + N);
         chk("R2 steer still comb", steer, 1'b0);
         tick(1);
         chk_mode("R2 bypass entered", 1'b1, 1'b1);

         if (s == 1) begin
            // R7: cancel pending entry
            req = s[0];
            tick(N + 6);
            chk_mode("R7 pending", 1'b1, 1'b0);
            req = ~s[0];
            tick(N + 6);
            pulse_vs();
            for (int k = 0; k < 10; k++) begin
               tick(1);
               chk_mode("R7 cancelled", 1'b1, 1'b1);
            end
         end else begin
            // R2: leave via select pin from comb
            req = 1'b0;
            tick(N + 8);
            chk_mode("R3 re-enter comb", 1'b0, 1'b0);
            sel = 1'b1;
            tick(2);
            chk("R2 sel steer old", steer, 1'b0);
            tick(1);
            chk_mode("R2 sel bypass", 1'b1, 1'b1);
            // R4: pulse while bypass has no effect
            pulse_vs();
            tick(5);
            chk_mode("R4 pulse in bypass", 1'b1, 1'b1);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule